// File: doc/BRIEF.md
# Smart Panel Command Sequencer

This block runs a stream of 16-bit command words against a display that keeps its own frame memory and is driven over an 8-bit parallel bus with a register-select line. Each word carries a 3-bit opcode in bits 11:9, the register-select value in bit 8 and a payload byte in bits 7:0. Words arrive on a valid/ready input; the block accepts one whenever it is idle and holds ready low until that word has finished.

The opcodes cover a command-byte or data-byte write, a status or memory read-back, a stall until the next vertical sync, a delay of 0 to 255 milliseconds timed by a prescaler on the block clock, and a sticky command interrupt. The frame-streaming opcode, the no-op and the undefined opcode are accepted and do nothing. Read results land in an 11-bit status word that the surrounding logic can inspect.

Top module: `panel_cmd_seq`

## Requirements
- R1: Opcode 1 (bits 11:9 = 3'b001) drives the payload (bits 7:0) on `bus_dout` and bit 8 on `bus_a0`, with `bus_oe` high; bit 8 = 0 marks a command byte, bit 8 = 1 a data byte.
- R2: A write raises `bus_oe` one clock before `bus_wr_n` falls, keeps `bus_wr_n` low for exactly STROBE_CLKS clocks, keeps `bus_oe` high for one clock after it rises, and holds ready low for STROBE_CLKS+2 clocks.
- R3: Opcode 0 sets `bus_a0` from bit 8, keeps `bus_rd_n` low for STROBE_CLKS clocks (one setup and one hold clock around it), and at the end of the strobe loads `rd_status` bits 7:0 with `bus_din`, bit 8 with the register-select value and sets bit 9 (read OK).
- R4: Status bit 10 (continue) is set when a read completes and cleared when the next command of any kind is accepted; bit 9 is cleared when the next read is accepted and is otherwise held.
- R5: Opcode 3 keeps ready low until a rising edge of `vsync` is seen after acceptance; a `vsync` that is already high at acceptance does not end the wait.
- R6: Opcode 6 keeps ready low for N*CLK_PER_MS+1 clocks, N being the payload; a payload of 0 takes one clock.
- R7: Opcode 5 sets `irq`, which stays set until `irq_clr` is high at a clock edge; when both happen at the same edge, `irq` ends set.
- R8: Opcode 4, opcode 2 (either bit 8 value) and opcode 7 are accepted with no busy cycle, no strobe and no change to `bus_a0`, `bus_dout`, `irq` or the read-OK and data bits of `rd_status`.
- R9: After reset ready is high, both strobes are high, `bus_oe`, `irq` and `rd_status` are zero; ready is low whenever a strobe is low.
- R10: Bits 15:12 of the command word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 16 | Command word: opcode 11:9, select 8, payload 7:0 |
| cmd_ready | output | 1 | Sequencer idle, word accepted when valid |
| vsync | input | 1 | Vertical sync from the panel |
| bus_a0 | output | 1 | Register-select line to the panel |
| bus_dout | output | 8 | Byte driven to the panel |
| bus_oe | output | 1 | Output enable for the data bus |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_din | input | 8 | Byte returned by the panel |
| rd_status | output | 11 | Read byte 7:0, select 8, OK 9, continue 10 |
| irq | output | 1 | Sticky command interrupt |
| irq_clr | input | 1 | Write-one-to-clear for `irq` |

## Verification
The bench builds the block with CLK_PER_MS = 10 and STROBE_CLKS = 3. The short prescaler lets the full 255 ms delay run in about 2,550 clocks, so the zero, one-step and maximum delay lengths are all checked exactly, and a three-clock strobe keeps the setup, strobe and hold phases separately visible at the ports.

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq #(
  parameter int CLK_PER_MS  = 50000,
  parameter int STROBE_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  output logic        cmd_ready,
  input  logic        vsync,
  output logic        bus_a0,
  output logic [7:0]  bus_dout,
  output logic        bus_oe,
  output logic        bus_wr_n,
  output logic        bus_rd_n,
  input  logic [7:0]  bus_din,
  output logic [10:0] rd_status,
  output logic        irq,
  input  logic        irq_clr
);
  localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int SW = $clog2(STROBE_CLKS + 1);
  localparam logic [2:0] OP_RD  = 3'd0;
  localparam logic [2:0] OP_WR  = 3'd1;
  localparam logic [2:0] OP_VS  = 3'd3;
  localparam logic [2:0] OP_IRQ = 3'd5;
  localparam logic [2:0] OP_DLY = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_WSET, S_WSTB, S_WHLD, S_RSET, S_RSTB, S_RHLD, S_VS, S_DLY
  } st_t;

  st_t          st;
  logic [SW-1:0] cnt;
  logic [PW-1:0] pre;
  logic [7:0]   ms_left;
  logic         vs_q;

  wire [2:0] op  = cmd_word[11:9];
  wire       sel = cmd_word[8];
  wire [7:0] pay = cmd_word[7:0];
  logic unused_hi;
  assign unused_hi = ^cmd_word[15:12];

  assign cmd_ready = (st == S_IDLE);
  assign bus_wr_n  = (st != S_WSTB);
  assign bus_rd_n  = (st != S_RSTB);
  assign bus_oe    = (st == S_WSET) || (st == S_WSTB) || (st == S_WHLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      pre       <= '0;
      ms_left   <= '0;
      vs_q      <= 1'b0;
      bus_a0    <= 1'b0;
      bus_dout  <= '0;
      rd_status <= '0;
      irq       <= 1'b0;
    end else begin
      vs_q <= vsync;
      if (irq_clr) irq <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          rd_status[10] <= 1'b0;
          case (op)
            OP_RD: begin
              bus_a0       <= sel;
              rd_status[9] <= 1'b0;
              st           <= S_RSET;
            end
            OP_WR: begin
              bus_a0   <= sel;
              bus_dout <= pay;
              st       <= S_WSET;
            end
            OP_VS:  st <= S_VS;
            OP_DLY: begin
              ms_left <= pay;
              pre     <= '0;
              st      <= S_DLY;
            end
            OP_IRQ: irq <= 1'b1;
            default: ;
          endcase
        end
        S_WSET: begin
          cnt <= '0;
          st  <= S_WSTB;
        end
        S_WSTB: begin
          if (cnt == SW'(STROBE_CLKS - 1)) st <= S_WHLD;
          else cnt <= cnt + 1'b1;
        end
        S_WHLD: st <= S_IDLE;
        S_RSET: begin
          cnt <= '0;
          st  <= S_RSTB;
        end
        S_RSTB: begin
          if (cnt == SW'(STROBE_CLKS - 1)) begin
            rd_status <= {1'b1, 1'b1, bus_a0, bus_din};
            st        <= S_RHLD;
          end else cnt <= cnt + 1'b1;
        end
        S_RHLD: st <= S_IDLE;
        S_VS: if (vsync && !vs_q) st <= S_IDLE;
        S_DLY: begin
          if (ms_left == 8'd0) st <= S_IDLE;
          else if (pre == PW'(CLK_PER_MS - 1)) begin
            pre     <= '0;
            ms_left <= ms_left - 8'd1;
          end else pre <= pre + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_cmd_seq_chk.sv
module panel_cmd_seq_chk #(
  parameter int STROBE_CLKS = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        bus_oe,
  input logic        bus_wr_n,
  input logic        bus_rd_n,
  input logic [10:0] rd_status,
  input logic        irq,
  input logic        irq_clr
);
  int wr_run;
  int rd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run <= 0;
      rd_run <= 0;
    end else begin
      wr_run <= bus_wr_n ? 0 : wr_run + 1;
      rd_run <= bus_rd_n ? 0 : rd_run + 1;
    end
  end

  p_busy_in_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n || !bus_rd_n) |-> !cmd_ready);
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));
  p_wr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $past(bus_oe));
  p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> bus_oe);
  p_wr_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (wr_run == STROBE_CLKS));
  p_rd_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> (rd_run == STROBE_CLKS));
  p_rd_ok_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> rd_status[9]);
  p_rd_ok_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_status[9]) |-> $rose(bus_rd_n));
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind panel_cmd_seq panel_cmd_seq_chk #(.STROBE_CLKS(STROBE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .bus_oe(bus_oe),
  .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .rd_status(rd_status),
  .irq(irq), .irq_clr(irq_clr)
);

// File: tb/panel_cmd_seq_tb.sv
module panel_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PMS = 10;
  localparam int SCL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        cmd_ready;
  logic        vsync = 1'b0;
  logic        bus_a0;
  logic [7:0]  bus_dout;
  logic        bus_oe;
  logic        bus_wr_n;
  logic        bus_rd_n;
  logic [7:0]  bus_din = '0;
  logic [10:0] rd_status;
  logic        irq;
  logic        irq_clr = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_cmd_seq #(.CLK_PER_MS(PMS), .STROBE_CLKS(SCL)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] hi, input logic [2:0] op,
                                     input logic a0, input logic [7:0] p);
    return {hi, op, a0, p};
  endfunction

  task automatic run_cmd(input logic [15:0] w, output int busy, output int wrl,
                         output int rdl, output bit setup_ok, output bit hold_ok);
    bit prev_lo = 0;
    @(negedge clk);
    cmd_word = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = 0; wrl = 0; rdl = 0; setup_ok = 0; hold_ok = 0;
    while (!cmd_ready && busy < 5000) begin
      if (busy == 0) setup_ok = bus_wr_n && bus_rd_n && (w[11:9] != 3'd1 || bus_oe);
      if (!bus_wr_n) wrl++;
      if (!bus_rd_n) rdl++;
      if (prev_lo && bus_wr_n && bus_rd_n) hold_ok = (w[11:9] != 3'd1) || bus_oe;
      prev_lo = !bus_wr_n || !bus_rd_n;
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(cmd_ready == 1'b1, "R9 ready", cmd_ready, 1);
    chk(bus_wr_n && bus_rd_n && !bus_oe, "R9 bus idle", {bus_wr_n, bus_rd_n, bus_oe}, 3'b110);
    chk(irq == 1'b0, "R9 irq", irq, 0);
    chk(rd_status == 11'd0, "R9 status", rd_status, 0);
  endtask

  task automatic t_write(input logic [3:0] hi, input logic a0, input logic [7:0] p);
    int b, wl, rl; bit su, ho;
    run_cmd(mk(hi, 3'd1, a0, p), b, wl, rl, su, ho);
    chk(bus_dout == p, "R1 write byte", bus_dout, p);
    chk(bus_a0 == a0, "R1 write select", bus_a0, a0);
    chk(wl == SCL, "R2 strobe width", wl, SCL);
    chk(rl == 0, "R2 no read strobe", rl, 0);
    chk(su && ho, "R2 setup/hold", {su, ho}, 2'b11);
    chk(b == SCL + 2, "R2 busy length", b, SCL + 2);
    if (hi != 4'h0) chk(b == SCL + 2 && bus_dout == p, "R10 upper bits ignored", bus_dout, p);
  endtask

  task automatic t_read(input logic a0, input logic [7:0] d);
    int b, wl, rl; bit su, ho;
    bus_din = d;
    run_cmd(mk(4'h0, 3'd0, a0, 8'h00), b, wl, rl, su, ho);
    chk(rl == SCL, "R3 read strobe width", rl, SCL);
    chk(wl == 0 && su && ho, "R3 setup/hold", {wl[0], su, ho}, 3'b011);
    chk(b == SCL + 2, "R3 busy length", b, SCL + 2);
    chk(rd_status == {2'b11, a0, d}, "R3 status word", rd_status, {2'b11, a0, d});
    chk(bus_a0 == a0, "R3 select line", bus_a0, a0);
  endtask

  task automatic t_status_flags;
    int b, wl, rl; bit su, ho;
    t_read(1'b0, 8'h5A);
    run_cmd(mk(4'h0, 3'd4, 1'b0, 8'h00), b, wl, rl, su, ho);
    chk(rd_status == {2'b01, 1'b0, 8'h5A}, "R4 continue cleared, ok kept",
        rd_status, {2'b01, 1'b0, 8'h5A});
    bus_din = 8'h11;
    @(negedge clk);
    cmd_word = mk(4'h0, 3'd0, 1'b1, 8'h00);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rd_status[9] == 1'b0, "R4 ok cleared at read start", rd_status[9], 0);
    while (!cmd_ready) @(negedge clk);
    chk(rd_status == {2'b11, 1'b1, 8'h11}, "R4 flags after read", rd_status, {2'b11, 1'b1, 8'h11});
  endtask

  task automatic t_vsync;
    int n;
    vsync = 1'b1;
    @(negedge clk);
    cmd_word = mk(4'h0, 3'd3, 1'b0, 8'h00);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    repeat (3) begin
      if (!cmd_ready) n++;
      @(negedge clk);
    end
    chk(n == 3, "R5 held vsync does not release", n, 3);
    vsync = 1'b0;
    repeat (2) @(negedge clk);
    chk(cmd_ready == 1'b0, "R5 still waiting", cmd_ready, 0);
    vsync = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R5 released on rising edge", cmd_ready, 1);
    vsync = 1'b0;
  endtask

  task automatic t_delay(input logic [7:0] ms);
    int b, wl, rl; bit su, ho;
    run_cmd(mk(4'h0, 3'd6, 1'b0, ms), b, wl, rl, su, ho);
    chk(b == int'(ms) * PMS + 1, "R6 delay length", b, int'(ms) * PMS + 1);
  endtask

  task automatic t_irq;
    int b, wl, rl; bit su, ho;
    run_cmd(mk(4'h0, 3'd5, 1'b0, 8'h00), b, wl, rl, su, ho);
    chk(irq == 1'b1 && b == 0, "R7 irq set", irq, 1);
    repeat (4) @(negedge clk);
    chk(irq == 1'b1, "R7 irq sticky", irq, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq == 1'b0, "R7 irq cleared", irq, 0);
    cmd_word = mk(4'h0, 3'd5, 1'b0, 8'h00);
    cmd_valid = 1'b1;
    irq_clr = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    irq_clr = 1'b0;
    chk(irq == 1'b1, "R7 set wins over clear", irq, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_noop(input logic [2:0] op, input logic a0);
    int b, wl, rl; bit su, ho;
    logic [7:0] d0; logic a00; logic [10:0] s0; logic i0;
    d0 = bus_dout; a00 = bus_a0; s0 = rd_status; i0 = irq;
    run_cmd(mk(4'h0, op, a0, 8'hE7), b, wl, rl, su, ho);
    chk(b == 0 && wl == 0 && rl == 0, "R8 no busy or strobe", b, 0);
    chk(bus_dout == d0 && bus_a0 == a00, "R8 bus unchanged", {bus_a0, bus_dout}, {a00, d0});
    chk(rd_status[9:0] == s0[9:0] && irq == i0, "R8 status and irq unchanged",
        {irq, rd_status[9:0]}, {i0, s0[9:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(4'h0, 1'b0, 8'h3C);
    t_write(4'hF, 1'b1, 8'hA5);
    t_read(1'b0, 8'h96);
    t_read(1'b1, 8'hC3);
    t_status_flags();
    t_vsync();
    t_delay(8'd0);
    t_delay(8'd1);
    t_delay(8'd3);
    t_delay(8'd255);
    t_irq();
    t_noop(3'd4, 1'b0);
    t_noop(3'd2, 1'b1);
    t_noop(3'd2, 1'b0);
    t_noop(3'd7, 1'b1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule